// File: doc/BRIEF.md
# Instruction Packet Grouping Checker

This block judges whether a group of instructions meant to issue together in a single cycle stays within the core's grouping limits. An upstream decoder has already turned each instruction into a descriptor. The descriptor gives the instruction's class, the number of program words it takes (extension words included) and two markers that flag the first and the last member of the group. Descriptors arrive one per cycle, qualified by a valid strobe.

Per-limit counters accumulate over the open group. The checker registers a verdict one cycle after the last descriptor: one accept bit, one violation flag per limit and a framing-error flag, all shown with a one-cycle done pulse. Prefix instructions (conditional prefix, loop marker, no-op) add their words to the word total. They take no instruction slot and no execution unit. A bit-mask instruction uses the bit-mask slot and also an address-unit slot. The counters saturate, so a very long group cannot wrap a counter back under a limit.

Class encoding on `in_cls`: 0 prefix, 1 data-ALU, 2 address-unit, 3 bit-mask, 4 extension-prefix opcode. Codes 5 to 7 are handled as prefix. Violation flag positions on `out_viol`: bit 0 instruction count, bit 1 word count, bit 2 address-unit, bit 3 bit-mask, bit 4 extension-prefix, bit 5 data-ALU.

Top module: `pkt_group_checker`

## Requirements
- R1: Every non-prefix descriptor (data-ALU, address-unit, bit-mask, extension-prefix) adds one to the instruction total, and prefix descriptors add nothing to it. `out_viol[0]` is set when this total exceeds MAX_INSNS (default 6).
- R2: Every accepted descriptor adds its `in_words` value to the word total, prefix descriptors included. `out_viol[1]` is set when the total exceeds MAX_WORDS (default 8).
- R3: Address-unit and bit-mask descriptors each add one to the address-unit total. `out_viol[2]` is set when this total exceeds MAX_ADDR (default 2).
- R4: `out_viol[3]` is set when the number of bit-mask descriptors exceeds MAX_BMU (default 1).
- R5: `out_viol[4]` is set when the number of extension-prefix descriptors exceeds MAX_EXT (default 1).
- R6: `out_viol[5]` is set when the number of data-ALU descriptors exceeds MAX_DALU (default 4). Prefix descriptors never count toward R3 to R6.
- R7: The verdict appears in the cycle after the descriptor that carries `in_last`, together with a one-cycle `out_done` pulse. `out_ok` is 1 exactly when no violation flag and no framing error is set. While `out_done` is 0, `out_ok`, `out_viol` and `out_frame_err` are all 0.
- R8: A descriptor with `in_first` clears all counters and starts a new group with its own contribution. If it arrives while a group is still open, the open group is dropped without a verdict and the new group's verdict carries `out_frame_err` = 1.
- R9: Counters saturate at 2^CNT_W-1 and do not wrap. A group that goes far past a limit is still flagged.
- R10: A valid descriptor without `in_first` that arrives while no group is open is ignored. It produces no `out_done`, even with `in_last` set, and it does not change the next group's verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_cls | input | 3 | Instruction class code |
| in_words | input | WORD_W | Program words of this instruction, extension words included |
| in_first | input | 1 | First descriptor of a group |
| in_last | input | 1 | Last descriptor of a group |
| out_done | output | 1 | One-cycle pulse: verdict valid |
| out_ok | output | 1 | Group accepted |
| out_viol | output | 6 | Per-limit violation flags |
| out_frame_err | output | 1 | Group started while another was open |

## Verification
The bench builds the block with its default parameters: limits 6/8/2/1/1/4, two-bit word fields and four-bit counters. With four-bit counters a group of only sixteen descriptors reaches the saturation point, so a twenty-instruction group shows whether a wrapped counter could let an oversized group pass. The small limits let short random groups of one to nine descriptors land on both sides of every limit. Directed groups sit exactly at each limit.

// File: rtl/grp_chk_pkg.sv
package grp_chk_pkg;

  typedef enum logic [2:0] {
    CLS_PREFIX  = 3'd0,
    CLS_DALU    = 3'd1,
    CLS_ADDR    = 3'd2,
    CLS_BITMASK = 3'd3,
    CLS_EXTPFX  = 3'd4
  } grp_cls_e;

  localparam int NUM_LIM  = 6;
  localparam int LIM_INSN = 0;
  localparam int LIM_WORD = 1;
  localparam int LIM_ADDR = 2;
  localparam int LIM_BMU  = 3;
  localparam int LIM_EXT  = 4;
  localparam int LIM_DALU = 5;

  // One-bit slot usage per limit; the word slot is filled elsewhere.
  function automatic logic [NUM_LIM-1:0] slot_use(input logic [2:0] cls);
    logic [NUM_LIM-1:0] u;
    u = '0;
    case (cls)
      CLS_DALU: begin
        u[LIM_INSN] = 1'b1;
        u[LIM_DALU] = 1'b1;
      end
      CLS_ADDR: begin
        u[LIM_INSN] = 1'b1;
        u[LIM_ADDR] = 1'b1;
      end
      CLS_BITMASK: begin
        u[LIM_INSN] = 1'b1;
        u[LIM_ADDR] = 1'b1;
        u[LIM_BMU]  = 1'b1;
      end
      CLS_EXTPFX: begin
        u[LIM_INSN] = 1'b1;
        u[LIM_EXT]  = 1'b1;
      end
      default: u = '0;
    endcase
    return u;
  endfunction

endpackage

// File: rtl/grp_desc_contrib.sv
module grp_desc_contrib
  import grp_chk_pkg::*;
#(
  parameter int WORD_W = 2,
  parameter int CNT_W  = 4
) (
  input  logic [2:0]                     cls,
  input  logic [WORD_W-1:0]              words,
  output logic [NUM_LIM-1:0][CNT_W-1:0]  inc
);

  logic [NUM_LIM-1:0] use_bits;

  always_comb use_bits = slot_use(cls);

  for (genvar g = 0; g < NUM_LIM; g++) begin : gen_inc
    if (g == LIM_WORD) begin : gen_word
      assign inc[g] = CNT_W'(words);
    end else begin : gen_slot
      assign inc[g] = CNT_W'(use_bits[g]);
    end
  end

endmodule

// File: rtl/grp_sat_counter.sv
module grp_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] inc,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  always_comb begin
    if (load)      cnt_nxt = inc;
    else if (step) cnt_nxt = sat_add(cnt_q, inc);
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/grp_limit_check.sv
module grp_limit_check
  import grp_chk_pkg::*;
#(
  parameter int                        CNT_W  = 4,
  parameter logic [NUM_LIM*CNT_W-1:0]  LIMITS = '0
) (
  input  logic [NUM_LIM-1:0][CNT_W-1:0] totals,
  output logic [NUM_LIM-1:0]            viol
);

  for (genvar g = 0; g < NUM_LIM; g++) begin : gen_cmp
    localparam logic [CNT_W-1:0] LIM = LIMITS[g*CNT_W +: CNT_W];
    assign viol[g] = totals[g] > LIM;
  end

endmodule

// File: rtl/pkt_group_checker.sv
module pkt_group_checker
  import grp_chk_pkg::*;
#(
  parameter int WORD_W    = 2,
  parameter int CNT_W     = 4,
  parameter int MAX_INSNS = 6,
  parameter int MAX_WORDS = 8,
  parameter int MAX_ADDR  = 2,
  parameter int MAX_BMU   = 1,
  parameter int MAX_EXT   = 1,
  parameter int MAX_DALU  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_cls,
  input  logic [WORD_W-1:0] in_words,
  input  logic              in_first,
  input  logic              in_last,
  output logic              out_done,
  output logic              out_ok,
  output logic [5:0]        out_viol,
  output logic              out_frame_err
);

  localparam logic [NUM_LIM*CNT_W-1:0] LIM_VEC = {
    CNT_W'(MAX_DALU), CNT_W'(MAX_EXT), CNT_W'(MAX_BMU),
    CNT_W'(MAX_ADDR), CNT_W'(MAX_WORDS), CNT_W'(MAX_INSNS)
  };

  // Named internal events, also used by the checker.
  logic ev_start, ev_step, ev_close, ev_restart;
  logic in_group_q, frame_q, frame_nxt;

  assign ev_start   = in_valid & in_first;
  assign ev_step    = in_valid & ~in_first & in_group_q;
  assign ev_restart = ev_start & in_group_q;
  assign ev_close   = (ev_start | ev_step) & in_last;
  assign frame_nxt  = ev_start ? in_group_q : frame_q;

  logic [NUM_LIM-1:0][CNT_W-1:0] inc;
  logic [NUM_LIM-1:0][CNT_W-1:0] cnt_all;
  logic [NUM_LIM-1:0][CNT_W-1:0] cnt_nxt;
  logic [NUM_LIM-1:0]            viol_nxt;

  grp_desc_contrib #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_contrib (
    .cls   (in_cls),
    .words (in_words),
    .inc   (inc)
  );

  for (genvar g = 0; g < NUM_LIM; g++) begin : gen_cnt
    grp_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ev_start),
      .step    (ev_step),
      .inc     (inc[g]),
      .cnt_q   (cnt_all[g]),
      .cnt_nxt (cnt_nxt[g])
    );
  end

  grp_limit_check #(.CNT_W(CNT_W), .LIMITS(LIM_VEC)) u_limits (
    .totals (cnt_nxt),
    .viol   (viol_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_group_q <= 1'b0;
      frame_q    <= 1'b0;
    end else begin
      if (ev_close)      in_group_q <= 1'b0;
      else if (ev_start) in_group_q <= 1'b1;
      frame_q <= ev_close ? 1'b0 : frame_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_done      <= 1'b0;
      out_ok        <= 1'b0;
      out_viol      <= '0;
      out_frame_err <= 1'b0;
    end else begin
      out_done <= ev_close;
      if (ev_close) begin
        out_viol      <= viol_nxt;
        out_frame_err <= frame_nxt;
        out_ok        <= ~(|viol_nxt) & ~frame_nxt;
      end else begin
        out_viol      <= '0;
        out_frame_err <= 1'b0;
        out_ok        <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pkt_group_checker_sva.sv
module pkt_group_checker_sva
  import grp_chk_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          in_last,
  input logic                          ev_close,
  input logic                          ev_step,
  input logic                          ev_restart,
  input logic [NUM_LIM-1:0][CNT_W-1:0] cnt_all,
  input logic                          out_done,
  input logic                          out_ok,
  input logic [5:0]                    out_viol,
  input logic                          out_frame_err
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  p_done_after_close_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_close |=> out_done);

  p_no_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_close |=> !out_done);

  p_ok_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_done && out_ok) |-> (out_viol == '0 && !out_frame_err));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> (out_viol == '0 && !out_ok && !out_frame_err));

  p_restart_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_restart && in_last) |=> out_frame_err);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && cnt_all[LIM_WORD] == CNT_MAX) |=> cnt_all[LIM_WORD] == CNT_MAX);

endmodule

bind pkt_group_checker pkt_group_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_last       (in_last),
  .ev_close      (ev_close),
  .ev_step       (ev_step),
  .ev_restart    (ev_restart),
  .cnt_all       (cnt_all),
  .out_done      (out_done),
  .out_ok        (out_ok),
  .out_viol      (out_viol),
  .out_frame_err (out_frame_err)
);

// File: tb/pkt_group_checker_tb_top.sv
module pkt_group_checker_tb_top;

  localparam int P_CLS = 0, D_CLS = 1, A_CLS = 2, B_CLS = 3, E_CLS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_cls = '0;
  logic [1:0] in_words = '0;
  logic       in_first = 1'b0;
  logic       in_last = 1'b0;
  logic       out_done, out_ok, out_frame_err;
  logic [5:0] out_viol;

  int checks = 0;
  int errors = 0;
  int g_cls [32];
  int g_w   [32];

  always #5 clk = ~clk;

  pkt_group_checker dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
    .in_words(in_words), .in_first(in_first), .in_last(in_last),
    .out_done(out_done), .out_ok(out_ok), .out_viol(out_viol),
    .out_frame_err(out_frame_err)
  );

  // Expected flags from plain integer totals (no saturation needed).
  function automatic logic [5:0] exp_viol(input int n);
    int ni = 0, nw = 0, na = 0, nb = 0, ne = 0, nd = 0;
    for (int i = 0; i < n; i++) begin
      nw += g_w[i];
      if (g_cls[i] == D_CLS) begin ni++; nd++; end
      if (g_cls[i] == A_CLS) begin ni++; na++; end
      if (g_cls[i] == B_CLS) begin ni++; na++; nb++; end
      if (g_cls[i] == E_CLS) begin ni++; ne++; end
    end
    return {nd > 4, ne > 1, nb > 1, na > 2, nw > 8, ni > 6};
  endfunction

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got done/ok/frame/viol=%b expected %b", req, act, exp);
    end
  endtask

  task automatic put(input int cls, input int w, input bit first, input bit last);
    in_valid = 1'b1;
    in_cls   = 3'(cls);
    in_words = 2'(w);
    in_first = first;
    in_last  = last;
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic run_group(input int n, input bit frame, input string req);
    logic [5:0] v;
    for (int i = 0; i < n; i++) put(g_cls[i], g_w[i], i == 0, i == n - 1);
    v = exp_viol(n);
    check(req, {out_done, out_ok, out_frame_err, out_viol},
          {1'b1, (v == 6'd0) && !frame, frame, v});
  endtask

  task automatic set(input int i, input int c, input int w);
    g_cls[i] = c;
    g_w[i]   = w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset", {out_done, out_ok, out_frame_err, out_viol}, 9'b0);

    // R2: jump, four data-ALU, long-immediate move (3 words), two prefixes = 10 words
    set(0, A_CLS, 1); set(1, D_CLS, 1); set(2, D_CLS, 1); set(3, D_CLS, 1);
    set(4, D_CLS, 1); set(5, A_CLS, 3); set(6, P_CLS, 1); set(7, P_CLS, 1);
    run_group(8, 0, "R2 word overflow");

    // R3: bit-mask plus two address moves
    set(0, B_CLS, 2); set(1, A_CLS, 1); set(2, A_CLS, 1);
    run_group(3, 0, "R3 addr overflow");

    // R1/R6 exactly at limits, prefixes excluded from instruction count
    set(0, D_CLS, 1); set(1, D_CLS, 1); set(2, D_CLS, 1); set(3, D_CLS, 1);
    set(4, A_CLS, 1); set(5, A_CLS, 1); set(6, P_CLS, 1); set(7, P_CLS, 1);
    run_group(8, 0, "R1 R6 at limit");

    // R1 seven instructions
    for (int i = 0; i < 7; i++) set(i, (i < 4) ? D_CLS : ((i < 6) ? A_CLS : E_CLS), 1);
    run_group(7, 0, "R1 seven insns");

    // R6 five data-ALU
    for (int i = 0; i < 5; i++) set(i, D_CLS, 1);
    run_group(5, 0, "R6 dalu overflow");

    // R4 two bit-mask
    set(0, B_CLS, 1); set(1, B_CLS, 1);
    run_group(2, 0, "R4 bitmask overflow");

    // R5 two extension-prefix opcodes
    set(0, E_CLS, 2); set(1, E_CLS, 2);
    run_group(2, 0, "R5 extpfx overflow");

    // R6 prefixes use no unit: many prefixes alone within word limit
    for (int i = 0; i < 8; i++) set(i, P_CLS, 1);
    run_group(8, 0, "R6 prefixes no unit");

    // R9 twenty data-ALU: counters saturate, never wrap to a pass
    for (int i = 0; i < 20; i++) set(i, D_CLS, 1);
    run_group(20, 0, "R9 saturation");

    // R8 restart while open: drop two, then new clean group flagged
    put(D_CLS, 1, 1, 0);
    put(D_CLS, 1, 0, 0);
    set(0, A_CLS, 1); set(1, D_CLS, 1);
    run_group(2, 1, "R8 framing restart");
    // R8 next group clean again
    set(0, D_CLS, 3);
    run_group(1, 0, "R8 counters cleared");

    // R10 stray descriptor outside any group
    put(B_CLS, 3, 0, 1);
    check("R10 stray ignored", {out_done, out_ok, out_frame_err, out_viol}, 9'b0);
    set(0, B_CLS, 1); set(1, A_CLS, 1);
    run_group(2, 0, "R10 next group unaffected");

    // Random groups
    for (int k = 0; k < 300; k++) begin
      int n;
      n = 1 + int'($urandom % 9);
      for (int i = 0; i < n; i++) begin
        int r;
        r = int'($urandom % 10);
        if (r < 2)       set(i, P_CLS, 1);
        else if (r < 5)  set(i, D_CLS, 1 + int'($urandom % 2));
        else if (r < 8)  set(i, A_CLS, 1 + int'($urandom % 3));
        else if (r == 8) set(i, B_CLS, 1 + int'($urandom % 2));
        else             set(i, E_CLS, 2);
      end
      run_group(n, 0, "R1 R2 R3 R4 R5 R6 random");
      if ($urandom % 3 == 0) begin
        @(negedge clk);
        check("R7 done single pulse", {out_done, out_ok, out_frame_err, out_viol}, 9'b0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule